// File: doc/BRIEF.md
# Conditional Relative Branch Resolver with Stall Counter

This block resolves a conditional relative branch for an 8-bit processor core. On a start request it reads a 4-bit branch selector, the four status flags, the program counter (already pointing past the offset operand) and an 8-bit signed displacement. In the same clock edge it registers three results: whether the branch is taken, the next program counter, and the total clock count of the instruction.

The clock count is 2 when the condition fails. It is 3 when the branch is taken and the target stays in the same 256-byte page as the incoming program counter. It is 4 when a taken branch lands in another page. A countdown then holds `ready` low for exactly that many clocks, and the core uses this as its stall.

A two-state machine controls the block. In `ST_IDLE` it raises `ready` and accepts a start; this is the *accept* transition to `ST_STALL`, which loads the counter. In `ST_STALL` it decrements the counter on every clock (the *count* transition back to `ST_STALL`). When the counter reaches zero it takes the *release* transition to `ST_IDLE`.

Top module: `rel_branch_resolver`

## Requirements
- R1: While `rst_n` is low and after its release, `ready` is 1 and `taken`, `next_pc` and `cycles` are 0.
- R2: The flags input is `{N,V,C,Z}` (bit 3 = N, bit 2 = V, bit 1 = C, bit 0 = Z). Selector bits [3:2] choose the flag (00=N, 01=V, 10=C, 11=Z). Selector bit 1 gives the flag value that takes the branch. Selector bit 0 has no effect, which gives eight distinct conditions.
- R3: A branch that is not taken reports `cycles`=2 and `next_pc` equal to the incoming program counter.
- R4: A taken branch whose target has the same high byte as the incoming program counter reports `cycles`=3 and `next_pc` = program counter + displacement.
- R5: The displacement is sign-extended. When bit 7 is 1, the upper byte is filled with ones, so the branch goes backward.
- R6: A taken branch whose target high byte differs from the incoming high byte reports `cycles`=4. This holds for both forward and backward crossings.
- R7: The target address wraps modulo 65536.
- R8: After an accepted start, `ready` is low for exactly `cycles` clocks and then returns high.
- R9: A start that is raised while `ready` is low is ignored. The outputs and the stall length do not change.
- R10: The outputs hold their values after the stall ends, until the next accepted start, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to resolve a branch; accepted only while `ready` is 1 |
| sel | input | 4 | Branch selector: flag choice [3:2], polarity [1], bit 0 ignored |
| flags | input | 4 | Status flags {N,V,C,Z} |
| pc_in | input | 16 | Program counter past the operand |
| offset | input | 8 | Signed displacement |
| ready | output | 1 | High when idle; low during the stall |
| taken | output | 1 | Registered branch decision |
| next_pc | output | 16 | Registered next program counter |
| cycles | output | 3 | Registered total clock count (2, 3 or 4) |

## Verification
The case hardest to produce from the ports is a start request that arrives in the middle of a stall. The stimulus first launches a 4-clock page-crossing branch, then raises start during the stall with inputs that would produce a different target and a different count, and checks that both the outputs and the stall length stay unchanged. A backward crossing is exercised with a negative displacement from the bottom of a page, and the wrap is exercised with a forward displacement from the top of memory and a backward one from address zero.

// File: rtl/rbr_pkg.sv
package rbr_pkg;
    localparam int BASE_CYCLES = 2;
    localparam int MAX_CYCLES  = BASE_CYCLES + 2;
    localparam int CNT_W       = $clog2(MAX_CYCLES + 1);

    typedef enum logic [1:0] {
        FLG_NEG = 2'b00,
        FLG_OVF = 2'b01,
        FLG_CRY = 2'b10,
        FLG_ZRO = 2'b11
    } flag_pick_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_STALL = 1'b1
    } stall_state_e;
endpackage

// File: rtl/rbr_cond_eval.sv
module rbr_cond_eval #(
    parameter int NFLAGS = 4
) (
    input  logic [3:0]        sel,
    input  logic [NFLAGS-1:0] flags,
    output logic              take
);
    localparam int NCOND = 2 * NFLAGS;

    // R2: condition table, one entry per (flag, polarity) pair
    logic [NCOND-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NFLAGS; g++) begin : g_flag
            assign hit[2*g]     = ~flags[NFLAGS-1-g];
            assign hit[2*g + 1] =  flags[NFLAGS-1-g];
        end
    endgenerate

    always_comb begin
        take = hit[{sel[3:2], sel[1]}];
    end
endmodule

// File: rtl/rbr_target_calc.sv
module rbr_target_calc
    import rbr_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int OFF_W     = 8,
    parameter int PAGE_BITS = 8
) (
    input  logic [PC_W-1:0]  pc_in,
    input  logic [OFF_W-1:0] offset,
    input  logic             take,
    output logic [PC_W-1:0]  next_pc,
    output logic [CNT_W-1:0] cycles
);
    localparam int EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] disp;
    logic [PC_W-1:0] target;
    logic            crossed;

    always_comb begin
        disp    = {{EXT_W{offset[OFF_W-1]}}, offset};   // R5
        target  = pc_in + disp;                          // R7: width wraps
        crossed = target[PC_W-1:PAGE_BITS] != pc_in[PC_W-1:PAGE_BITS];
        if (!take) begin
            next_pc = pc_in;
            cycles  = CNT_W'(BASE_CYCLES);
        end else if (crossed) begin
            next_pc = target;
            cycles  = CNT_W'(BASE_CYCLES + 2);
        end else begin
            next_pc = target;
            cycles  = CNT_W'(BASE_CYCLES + 1);
        end
    end
endmodule

// File: rtl/rbr_stall_fsm.sv
module rbr_stall_fsm
    import rbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load_cycles,
    output logic             ready,
    output logic             accept
);
    stall_state_e     state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_STALL;
                    cnt_nx   = load_cycles;
                end
            end
            ST_STALL: begin
                cnt_nx = cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    state_nx = ST_IDLE;
                end
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        ready  = (state == ST_IDLE);
        accept = (state == ST_IDLE) && start;
    end

    p_stall_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STALL) |-> (cnt != '0));
    p_accept_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (cnt == $past(load_cycles)) && !ready);
    p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STALL && cnt > CNT_W'(1)) |=> (state == ST_STALL) && (cnt == $past(cnt) - 1'b1));
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STALL && cnt == CNT_W'(1)) |=> ready);
endmodule

// File: rtl/rel_branch_resolver.sv
module rel_branch_resolver
    import rbr_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int OFF_W     = 8,
    parameter int PAGE_BITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [3:0]       sel,
    input  logic [3:0]       flags,
    input  logic [PC_W-1:0]  pc_in,
    input  logic [OFF_W-1:0] offset,
    output logic             ready,
    output logic             taken,
    output logic [PC_W-1:0]  next_pc,
    output logic [CNT_W-1:0] cycles
);
    logic             take_c;
    logic [PC_W-1:0]  npc_c;
    logic [CNT_W-1:0] cyc_c;
    logic             accept;

    rbr_cond_eval #(.NFLAGS(4)) i_cond (
        .sel   (sel),
        .flags (flags),
        .take  (take_c)
    );

    rbr_target_calc #(.PC_W(PC_W), .OFF_W(OFF_W), .PAGE_BITS(PAGE_BITS)) i_calc (
        .pc_in   (pc_in),
        .offset  (offset),
        .take    (take_c),
        .next_pc (npc_c),
        .cycles  (cyc_c)
    );

    rbr_stall_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .load_cycles (cyc_c),
        .ready       (ready),
        .accept      (accept)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken   <= 1'b0;
            next_pc <= '0;
            cycles  <= '0;
        end else if (accept) begin
            taken   <= take_c;
            next_pc <= npc_c;
            cycles  <= cyc_c;
        end
    end

    p_not_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !take_c) |=> (next_pc == $past(pc_in)) && (cycles == CNT_W'(BASE_CYCLES)) && !taken);
    p_taken_cost_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && take_c) |=> taken && (cycles > CNT_W'(BASE_CYCLES)));
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(next_pc) && $stable(cycles) && $stable(taken));
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> $stable(next_pc) && $stable(cycles));
endmodule

// File: tb/test_rel_branch_resolver.sv
`timescale 1ns/1ps
module test_rel_branch_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  sel = '0;
    logic [3:0]  flags = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  offset = '0;
    logic        ready, taken;
    logic [15:0] next_pc;
    logic [2:0]  cycles;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rel_branch_resolver i_rel_branch_resolver (
        .clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .flags(flags),
        .pc_in(pc_in), .offset(offset), .ready(ready), .taken(taken),
        .next_pc(next_pc), .cycles(cycles)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // independent model: flags {N,V,C,Z}, sel[3:2] picks N/V/C/Z, sel[1] polarity
    function automatic bit m_take(input logic [3:0] s, input logic [3:0] f);
        return f[3 - s[3:2]] == s[1];
    endfunction
    function automatic logic [15:0] m_target(input logic [15:0] p, input logic [7:0] o);
        int t;
        t = (int'(p) + int'($signed(o))) & 32'hFFFF;
        return t[15:0];
    endfunction
    function automatic int m_cycles(input bit tk, input logic [15:0] p, input logic [7:0] o);
        logic [15:0] t;
        t = m_target(p, o);
        if (!tk) return 2;
        return (t[15:8] != p[15:8]) ? 4 : 3;
    endfunction

    int stall_len;

    // drive one branch, check outputs and stall length
    task automatic run_branch(input logic [3:0] s, input logic [3:0] f,
                              input logic [15:0] p, input logic [7:0] o, input string req);
        bit tk;
        logic [15:0] exp_pc;
        int exp_c;
        tk = m_take(s, f);
        exp_pc = tk ? m_target(p, o) : p;
        exp_c = m_cycles(tk, p, o);
        @(negedge clk);
        sel = s; flags = f; pc_in = p; offset = o; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(taken == tk, {req, " taken"}, taken, tk);
        check(next_pc == exp_pc, {req, " next_pc"}, next_pc, exp_pc);
        check(cycles == 3'(exp_c), {req, " cycles"}, cycles, exp_c);
        stall_len = 0;
        while (!ready && stall_len < 10) begin
            stall_len++;
            @(negedge clk);
        end
        check(stall_len == exp_c, {req, " stall length R8"}, stall_len, exp_c);
    endtask

    task automatic t_reset_r1();
        @(negedge clk);
        check(ready == 1'b1 && taken == 1'b0, "R1 ready/taken in reset", {ready, taken}, 2'b10);
        check(next_pc == 16'h0 && cycles == 3'd0, "R1 pc/cycles in reset", {next_pc, cycles}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b1 && next_pc == 16'h0, "R1 after release", {ready, next_pc}, 17'h10000);
    endtask

    task automatic t_conditions_r2();
        for (int s = 0; s < 16; s++) begin
            run_branch(4'(s), 4'b0000, 16'h4010, 8'h05, "R2 flags clear");
            run_branch(4'(s), 4'b1111, 16'h4010, 8'h05, "R2 flags set");
        end
        // only the chosen flag matters
        run_branch(4'b0010, 4'b0111, 16'h4010, 8'h05, "R2 N set only other flags");
        run_branch(4'b1110, 4'b0001, 16'h4010, 8'h05, "R2 Z only");
    endtask

    task automatic t_not_taken_r3();
        run_branch(4'b1000, 4'b0010, 16'h12F0, 8'h40, "R3 carry set, branch-if-clear");
    endtask

    task automatic t_same_page_r4();
        run_branch(4'b1100, 4'b0000, 16'h2030, 8'h10, "R4 forward same page");
    endtask

    task automatic t_sign_r5();
        run_branch(4'b1110, 4'b0001, 16'h2030, 8'hF0, "R5 backward same page");
        run_branch(4'b0000, 4'b0000, 16'h2080, 8'h80, "R5 most negative");
    endtask

    task automatic t_cross_r6();
        run_branch(4'b0100, 4'b0000, 16'h30F8, 8'h10, "R6 forward cross");
        run_branch(4'b0110, 4'b0100, 16'h3002, 8'hFC, "R6 backward cross");
    endtask

    task automatic t_wrap_r7();
        run_branch(4'b1010, 4'b0010, 16'hFFF8, 8'h10, "R7 wrap up");
        run_branch(4'b1010, 4'b0010, 16'h0003, 8'hF0, "R7 wrap down");
    endtask

    task automatic t_busy_r9();
        logic [15:0] exp_pc;
        exp_pc = m_target(16'h50FE, 8'h04);
        @(negedge clk);
        sel = 4'b1110; flags = 4'b0001; pc_in = 16'h50FE; offset = 8'h04; start = 1'b1;
        @(negedge clk);
        // busy now: present different request
        sel = 4'b0000; flags = 4'b1000; pc_in = 16'h7777; offset = 8'h01;
        stall_len = 1;
        @(negedge clk);
        check(next_pc == exp_pc, "R9 next_pc during busy start", next_pc, exp_pc);
        check(cycles == 3'd4, "R9 cycles during busy start", cycles, 4);
        stall_len++;
        start = 1'b0;
        @(negedge clk);
        while (!ready && stall_len < 10) begin
            stall_len++;
            @(negedge clk);
        end
        check(stall_len == 4, "R9 stall length unchanged", stall_len, 4);
        check(next_pc == exp_pc, "R9 next_pc after stall", next_pc, exp_pc);
    endtask

    task automatic t_hold_r10();
        logic [15:0] p;
        logic [2:0] c;
        run_branch(4'b1100, 4'b0000, 16'h6000, 8'h20, "R10 setup");
        p = next_pc; c = cycles;
        sel = 4'b1110; flags = 4'b1111; pc_in = 16'h1234; offset = 8'h99;
        repeat (5) @(negedge clk);
        check(next_pc == p && cycles == c && ready, "R10 outputs hold", {next_pc, cycles}, {p, c});
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset_r1();
        t_conditions_r2();
        t_not_taken_r3();
        t_same_page_r4();
        t_sign_r5();
        t_cross_r6();
        t_wrap_r7();
        t_busy_r9();
        t_hold_r10();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule